// File: doc/BRIEF.md
# I2C Receive Data Holding Register

This block sits between an I2C byte shifter and the CPU bus. Each time the shifter finishes a byte it pulses a strobe with the byte value. The block places that byte in an 8-bit register that the CPU can only read. Behind the register there is a one-byte pending stage, so a byte that arrives before the CPU has read the previous one is kept instead of lost. A CPU read empties the register. If a byte is pending, the same read moves it forward into the register.

The block keeps two flags. The buffer-full flag shows that the register holds an unread byte. The receive interrupt flag is set by every load into the register and stays set until it is cleared on purpose.

In slave mode, while the address-match indication is high, the read port shows the calling address captured from the master. At all other times it shows the last data byte loaded. Clearing the module enable stops all loads, drops any pending byte and forces both flags low.

Top module: `i2c_rx_hold`

## Requirements
- R1: After reset, readData is 0x00 and both bufFull and irqFlag are 0.
- R2: With enable=1 and the register empty, a byteValid pulse loads byteIn into the register. The byte is visible on readData after the next clock edge, and bufFull rises in that same cycle.
- R3: Every load into the register sets irqFlag. irqFlag then stays 1 until irqClear is asserted, independent of bufFull. A load and an irqClear in the same cycle leave irqFlag at 1.
- R4: cpuRead while bufFull=1 clears bufFull when nothing is pending. readData keeps the byte that was just read.
- R5: A byte that arrives while the register is full goes to the pending stage, and readData does not change. The next cpuRead loads the pending byte, keeps bufFull at 1 and sets irqFlag.
- R6: A byte that arrives while both the register and the pending stage are full is discarded.
- R7: In slave mode (isMaster=0), while addrMatch=1, readData shows the last byte received with isMaster=0 and addrMatch=1. With addrMatch=0, readData shows the register.
- R8: In master mode (isMaster=1), addrMatch has no effect on readData. A byte received in master mode does not replace the captured calling address.
- R9: While enable=0, byteValid, cpuRead and irqClear have no effect, the pending byte is dropped, bufFull and irqFlag read 0, and readData keeps its last data byte.
- R10: cpuRead while bufFull=0 changes neither readData nor the flags.
- R11: When cpuRead and byteValid occur in the same cycle with nothing pending, the new byte goes straight into the register and bufFull stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable |
| isMaster | input | 1 | 1 = master mode, 0 = slave mode |
| addrMatch | input | 1 | Calling address matched (used in slave mode only) |
| byteValid | input | 1 | One-cycle pulse: shifter finished a byte |
| byteIn | input | 8 | Byte from the shifter |
| cpuRead | input | 1 | CPU read strobe for the register |
| irqClear | input | 1 | Clears the receive interrupt flag |
| readData | output | 8 | Register contents or calling address |
| bufFull | output | 1 | Register holds an unread byte |
| irqFlag | output | 1 | Receive interrupt flag |

## Verification
The assertions check on every clock the flag rules that hold cycle by cycle:
- a load into an empty register raises both flags;
- a disabled block has both flags low;
- irqFlag stays set when no clear is given;
- an unread register in master mode keeps its value.

Whether a byte goes to the pending stage, moves forward or is discarded depends on the order of earlier events, so only the bench's scenarios can show it. The same holds for which byte reaches readData in slave address mode, for the disable flush, and for the long pseudo-random sweep that the bench checks against its own arithmetic model of the requirements.

// File: rtl/i2c_rx_hold_pkg.sv
package i2c_rx_hold_pkg;

  typedef struct packed {
    logic loadDirect;  // byteIn goes straight into the register
    logic loadPend;    // pending byte moves into the register
    logic toPend;      // byteIn is parked in the pending stage
    logic capAddr;     // byteIn is a calling address in slave mode
    logic showAddr;    // read port selects the captured address
  } rxStrobes_t;

endpackage

// File: rtl/i2c_rx_hold_ctrl.sv
module i2c_rx_hold_ctrl
  import i2c_rx_hold_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       isMaster,
  input  logic       addrMatch,
  input  logic       byteValid,
  input  logic       cpuRead,
  input  logic       irqClear,
  output rxStrobes_t strobes,
  output logic       bufFull,
  output logic       irqFlag
);

  logic holdFull;
  logic pendValid;
  logic readEff;
  logic roomNow;
  logic anyLoad;

  always_comb begin
    readEff = enable && cpuRead && holdFull;
    roomNow = !holdFull || (readEff && !pendValid);

    strobes.loadPend   = readEff && pendValid;
    strobes.loadDirect = enable && byteValid && roomNow;
    strobes.toPend     = enable && byteValid && !roomNow
                         && (!pendValid || strobes.loadPend);
    strobes.capAddr    = enable && byteValid && !isMaster && addrMatch;
    strobes.showAddr   = !isMaster && addrMatch;

    anyLoad = strobes.loadDirect || strobes.loadPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull  <= 1'b0;
      pendValid <= 1'b0;
      irqFlag   <= 1'b0;
    end else if (!enable) begin
      holdFull  <= 1'b0;
      pendValid <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      if (anyLoad) begin
        holdFull <= 1'b1;
      end else if (readEff) begin
        holdFull <= 1'b0;
      end

      if (strobes.toPend) begin
        pendValid <= 1'b1;
      end else if (strobes.loadPend) begin
        pendValid <= 1'b0;
      end

      if (anyLoad) begin
        irqFlag <= 1'b1;
      end else if (irqClear) begin
        irqFlag <= 1'b0;
      end
    end
  end

  assign bufFull = holdFull;

endmodule

// File: rtl/i2c_rx_hold_dp.sv
module i2c_rx_hold_dp
  import i2c_rx_hold_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strobes,
  input  logic [DATA_W-1:0] byteIn,
  output logic [DATA_W-1:0] readData
);

  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] pendReg;
  logic [DATA_W-1:0] addrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= ZERO;
      pendReg <= ZERO;
      addrReg <= ZERO;
    end else begin
      if (strobes.loadPend) begin
        holdReg <= pendReg;
      end else if (strobes.loadDirect) begin
        holdReg <= byteIn;
      end

      if (strobes.toPend) begin
        pendReg <= byteIn;
      end

      if (strobes.capAddr) begin
        addrReg <= byteIn;
      end
    end
  end

  assign readData = strobes.showAddr ? addrReg : holdReg;

endmodule

// File: rtl/i2c_rx_hold.sv
module i2c_rx_hold
  import i2c_rx_hold_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              isMaster,
  input  logic              addrMatch,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteIn,
  input  logic              cpuRead,
  input  logic              irqClear,
  output logic [DATA_W-1:0] readData,
  output logic              bufFull,
  output logic              irqFlag
);

  rxStrobes_t strobes;

  i2c_rx_hold_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .isMaster  (isMaster),
    .addrMatch (addrMatch),
    .byteValid (byteValid),
    .cpuRead   (cpuRead),
    .irqClear  (irqClear),
    .strobes   (strobes),
    .bufFull   (bufFull),
    .irqFlag   (irqFlag)
  );

  i2c_rx_hold_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .byteIn   (byteIn),
    .readData (readData)
  );

endmodule

// File: rtl/i2c_rx_hold_chk.sv
module i2c_rx_hold_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              isMaster,
  input logic              addrMatch,
  input logic              byteValid,
  input logic [DATA_W-1:0] byteIn,
  input logic              cpuRead,
  input logic              irqClear,
  input logic [DATA_W-1:0] readData,
  input logic              bufFull,
  input logic              irqFlag
);

  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    enable && byteValid && !bufFull |=> bufFull); // R2

  AST_LOAD_SETS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    enable && byteValid && !bufFull |=> irqFlag); // R3

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    enable && irqFlag && !irqClear |=> irqFlag); // R3

  AST_FULL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    enable && bufFull && !cpuRead && isMaster ##1 isMaster |-> $stable(readData)); // R5

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    enable && bufFull && !cpuRead |=> bufFull); // R4

  AST_DISABLED_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !bufFull && !irqFlag); // R9

  AST_EMPTY_READ_NOP: assert property (@(posedge clk) disable iff (!rstN)
    enable && !bufFull && !byteValid && isMaster ##1 isMaster |-> !bufFull && $stable(readData)); // R10

  AST_BYTE_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> !$isunknown(byteIn) && !$isunknown(addrMatch)); // R7

endmodule

bind i2c_rx_hold i2c_rx_hold_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .isMaster  (isMaster),
  .addrMatch (addrMatch),
  .byteValid (byteValid),
  .byteIn    (byteIn),
  .cpuRead   (cpuRead),
  .irqClear  (irqClear),
  .readData  (readData),
  .bufFull   (bufFull),
  .irqFlag   (irqFlag)
);

// File: tb/i2c_rx_hold_tb.sv
module i2c_rx_hold_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       isMaster = 1'b0;
  logic       addrMatch = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic       cpuRead = 1'b0;
  logic       irqClear = 1'b0;
  logic [7:0] readData;
  logic       bufFull;
  logic       irqFlag;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // bench model of the requirements
  logic [7:0] mHold = 8'h00, mPend = 8'h00, mAddr = 8'h00;
  bit mFull = 0, mPendV = 0, mIrq = 0;

  always #2.5 clk = ~clk;

  i2c_rx_hold u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .isMaster(isMaster),
    .addrMatch(addrMatch), .byteValid(byteValid), .byteIn(byteIn),
    .cpuRead(cpuRead), .irqClear(irqClear), .readData(readData),
    .bufFull(bufFull), .irqFlag(irqFlag)
  );

  task automatic compare(input string req);
    logic [7:0] expData;
    expData = (!isMaster && addrMatch) ? mAddr : mHold;
    compared++;
    if (readData !== expData || bufFull !== mFull || irqFlag !== mIrq) begin
      mismatched++;
      $display("FAIL %s: data/full/irq actual %h/%b/%b expected %h/%b/%b",
               req, readData, bufFull, irqFlag, expData, mFull, mIrq);
    end
  endtask

  task automatic modelClock();
    bit load;
    load = 0;
    if (!enable) begin
      mFull = 0; mIrq = 0; mPendV = 0;
    end else begin
      if (byteValid && !isMaster && addrMatch) mAddr = byteIn;
      if (cpuRead && mFull) begin
        mFull = 0;
        if (mPendV) begin
          mHold = mPend; mPendV = 0; mFull = 1; load = 1;
        end
      end
      if (byteValid) begin
        if (!mFull) begin
          mHold = byteIn; mFull = 1; load = 1;
        end else if (!mPendV) begin
          mPend = byteIn; mPendV = 1;
        end
      end
      if (load) mIrq = 1;
      else if (irqClear) mIrq = 0;
    end
  endtask

  // drive at negedge, model at posedge, compare at following negedge
  task automatic step(input bit en, input bit ms, input bit am, input bit bv,
                      input logic [7:0] b, input bit rd, input bit clr,
                      input string req);
    enable = en; isMaster = ms; addrMatch = am; byteValid = bv;
    byteIn = b; cpuRead = rd; irqClear = clr;
    @(posedge clk);
    modelClock();
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle(input bit ms, input bit am, input string req);
    step(1, ms, am, 0, 8'h00, 0, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    compare("R1");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2 load into empty register
    step(1, 1, 0, 1, 8'hA5, 0, 0, "R2");
    // R3 irq sticky, then cleared, full stays
    idle(1, 0, "R3");
    step(1, 1, 0, 0, 8'h00, 0, 1, "R3");
    // R4 read clears full, data kept
    step(1, 1, 0, 0, 8'h00, 1, 0, "R4");
    // R10 read while empty
    step(1, 1, 0, 0, 8'h00, 1, 0, "R10");
    // R3 load plus clear: set wins
    step(1, 1, 0, 1, 8'h3C, 0, 1, "R3");
    step(1, 1, 0, 0, 8'h00, 1, 1, "R4");
    // R5 pending
    step(1, 1, 0, 1, 8'h11, 0, 0, "R5");
    step(1, 1, 0, 0, 8'h00, 0, 1, "R5");
    step(1, 1, 0, 1, 8'h22, 0, 0, "R5");
    step(1, 1, 0, 0, 8'h00, 1, 0, "R5");
    step(1, 1, 0, 0, 8'h00, 1, 0, "R5");
    // R6 discard when both full
    step(1, 1, 0, 1, 8'h33, 0, 0, "R6");
    step(1, 1, 0, 1, 8'h44, 0, 0, "R6");
    step(1, 1, 0, 1, 8'h45, 0, 0, "R6");
    step(1, 1, 0, 0, 8'h00, 1, 0, "R6");
    step(1, 1, 0, 0, 8'h00, 1, 0, "R6");
    step(1, 1, 0, 0, 8'h00, 1, 0, "R6");
    // R11 simultaneous read and arrival
    step(1, 1, 0, 1, 8'h55, 0, 0, "R11");
    step(1, 1, 0, 1, 8'h66, 1, 0, "R11");
    step(1, 1, 0, 0, 8'h00, 1, 0, "R11");
    // R7 slave calling address
    step(1, 0, 1, 1, 8'hA0, 0, 0, "R7");
    step(1, 0, 1, 0, 8'h00, 1, 0, "R7");
    step(1, 0, 0, 1, 8'h77, 0, 0, "R7");
    idle(0, 1, "R7");
    idle(0, 0, "R7");
    // R8 master ignores addrMatch
    idle(1, 1, "R8");
    step(1, 1, 1, 0, 8'h00, 1, 0, "R8");
    step(1, 1, 1, 1, 8'h99, 0, 0, "R8");
    idle(0, 1, "R8");
    // R9 disable
    step(1, 1, 0, 1, 8'hC1, 0, 0, "R9");
    step(0, 1, 0, 1, 8'hC2, 0, 0, "R9");
    step(0, 1, 0, 1, 8'hC3, 1, 1, "R9");
    step(1, 1, 0, 0, 8'h00, 1, 0, "R9");
    idle(1, 0, "R9");

    // pseudo-random sweep over all control combinations
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] != 4'h0, lfsr[4], lfsr[5], lfsr[6] | lfsr[7],
           lfsr[15:8], lfsr[8] & lfsr[9], lfsr[10] & lfsr[11] & lfsr[12],
           "R5 sweep");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule